// File: doc/BRIEF.md
# Peripheral Bus Cycle Timing Controller

This block shapes the bus clock strobe for a small processor's peripheral and user-memory accesses. It runs on a timing clock at twice the bus rate, so each edge of that clock is one half-period tick. A plain access lasts two ticks: the strobe is high for one tick, then low for one. Two kinds of one-period stretch exist, and they have different shapes. A wait state keeps the high phase at one tick and makes the low phase three ticks long. An extended cycle has the same total length, but the strobe is high for two ticks and low for two.

The peripheral address space has 32 word locations. The eight highest locations, 0x18 through 0x1F, belong to an external peripheral bus. For a peripheral read or write that hits this range, the block asserts an external select and drives address bits 2:0 out for the whole access. Every access moves one 16-bit word, but the data path is not part of this block. Two configuration bits select extended cycles. The register file decodes them from bit 7 (user-memory extend) and bit 13 (external-read extend) of the processor's configuration word. This block holds copies of both bits.

A request is accepted on the first edge where `req_valid` is high and the block is either idle or in the final tick of a cycle. The caller holds the request until `busy` shows that it was taken.

Top module: `pbus_cycle_ctrl`

## Requirements
- R1: After reset, `pclk`, `busy`, `done`, `ext_sel` and `ext_addr` are all 0, and both extend bits are cleared, so a user-memory access takes the plain two-tick shape until a bit is set again.
- R2: A plain access (no wait, no extension) raises `pclk` on the tick after acceptance, holds it high for 1 tick and low for 1 tick, and `done` is 1 only in the final low tick.
- R3: With `req_wait`=1 and no extension, `pclk` is high for 1 tick and low for 3 ticks.
- R4: With the user-extend bit set (configuration bit 7, input `cfg_cyc_ext`), every user-memory access (`req_kind`=1) is high for 2 ticks and low for 2 ticks.
- R5: With the read-extend bit set (configuration bit 13, input `cfg_rd_ext`), a peripheral read (`req_kind`=2) of an external address is high 2 / low 2, and a peripheral write (`req_kind`=3) stays high 1 / low 1.
- R6: The read-extend bit has no effect on user-memory accesses or on reads of internal addresses. The user-extend bit has no effect on peripheral reads.
- R7: A peripheral request (`req_kind` 2 or 3) with address 0x18–0x1F sets `ext_sel`=1 and `ext_addr`=address[2:0]. Both hold steady from the tick after acceptance through the `done` tick.
- R8: An address below 0x18, and any request of kind 0 (other) or 1 (user), leaves `ext_sel`=0 and `ext_addr`=0 for the entire cycle.
- R9: Extension combined with `req_wait`=1 gives high 2 ticks and low 4 ticks.
- R10: A request present during the `done` tick starts with no idle gap: `pclk` is high in the very next tick.
- R11: `busy` is 1 from the tick after acceptance through the `done` tick, and 0 when no cycle is running. `pclk` and `ext_sel` are 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the bus rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the two extend bits |
| cfg_cyc_ext | input | 1 | User-memory extend bit (configuration bit 7) |
| cfg_rd_ext | input | 1 | External-read extend bit (configuration bit 13) |
| req_valid | input | 1 | Access request pending |
| req_kind | input | 2 | 0 other, 1 user memory, 2 peripheral read, 3 peripheral write |
| req_addr | input | 5 | Peripheral word address |
| req_wait | input | 1 | Insert one wait state into this access |
| pclk | output | 1 | Bus clock strobe |
| ext_addr | output | 3 | External peripheral address |
| ext_sel | output | 1 | External peripheral bus selected |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | Final tick of the current cycle |

## Verification
The checker enforces these rules on every tick: `done` only occurs while the strobe is low and a cycle is running, the idle state is quiet, the external select and address do not change in the middle of a cycle, a high phase never lasts more than two ticks, and a request waiting at `done` produces a rising strobe on the next tick. Only the bench's scenarios can measure the exact high and low lengths for each combination of kind, address, wait and extend bit. The same holds for showing that a write or an internal read ignores the read-extend bit, and that reset clears the extend bits.

// File: rtl/pbt_pkg.sv
// Shared request encoding for the peripheral bus timing controller.
package pbt_pkg;
    typedef enum logic [1:0] {
        REQ_OTHER = 2'd0,
        REQ_USER  = 2'd1,
        REQ_PRD   = 2'd2,
        REQ_PWR   = 2'd3
    } req_kind_e;
endpackage

// File: rtl/pbt_addr_dec.sv
// Address decode: finds requests that target the external peripheral window,
// which is the top 2**EXT_AW locations of a 2**ADDR_W space.
// Assumes only peripheral read/write kinds may reach the external bus.
module pbt_addr_dec #(
    parameter int ADDR_W = 5,
    parameter int EXT_AW = 3
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ext,
    output logic [EXT_AW-1:0] ext_addr
);
    import pbt_pkg::*;

    localparam int HI_W = ADDR_W - EXT_AW;

    logic periph;
    logic in_window;

    // Window hit needs every high address bit set.
    always_comb begin
        periph    = (kind == REQ_PRD) || (kind == REQ_PWR);
        in_window = &addr[ADDR_W-1:ADDR_W-HI_W];
        is_ext    = periph && in_window;
        ext_addr  = is_ext ? addr[EXT_AW-1:0] : '0;
    end
endmodule

// File: rtl/pbt_shape.sv
// Picks the high and low phase lengths in half-period ticks for one access.
// Extension stretches both phases by one tick; a wait adds two low ticks.
module pbt_shape #(
    parameter int CNT_W = 3
) (
    input  logic [1:0]       kind,
    input  logic             is_ext,
    input  logic             wait_st,
    input  logic             cyc_ext,
    input  logic             rd_ext,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);
    import pbt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic stretch;

    // Stretch rules per request kind, then phase lengths.
    always_comb begin
        stretch = ((kind == REQ_USER) && cyc_ext) ||
                  ((kind == REQ_PRD) && is_ext && rd_ext);
        hi_len  = stretch ? TWO : ONE;
        lo_len  = (stretch ? TWO : ONE) + (wait_st ? TWO : '0);
    end
endmodule

// File: rtl/pbt_phase_gen.sv
// Strobe sequencer: runs a high phase then a low phase with lengths taken at
// acceptance. A new request is taken when idle or in the final tick.
// Assumes hi_len and lo_len are at least 1.
module pbt_phase_gen #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             accept,
    output logic             pclk,
    output logic             busy,
    output logic             done
);
    logic             busy_q;
    logic             pclk_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lo_q;

    // Final tick flag and acceptance.
    always_comb begin
        done   = busy_q && !pclk_q && (cnt_q == '0);
        accept = start_req && (!busy_q || done);
    end

    // Phase counter and strobe state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pclk_q <= 1'b0;
            cnt_q  <= '0;
            lo_q   <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            pclk_q <= 1'b1;
            cnt_q  <= hi_len - CNT_W'(1);
            lo_q   <= lo_len;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (pclk_q) begin
                pclk_q <= 1'b0;
                cnt_q  <= lo_q - CNT_W'(1);
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign pclk = pclk_q;
    assign busy = busy_q;
endmodule

// File: rtl/pbus_cycle_ctrl.sv
// Top: peripheral/user bus cycle timing. Holds the two extend bits, decodes
// the external window, shapes the strobe and registers the external address.
// Assumes the caller holds req_* stable until the request is accepted.
module pbus_cycle_ctrl #(
    parameter int ADDR_W = 5,
    parameter int EXT_AW = 3,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_cyc_ext,
    input  logic              cfg_rd_ext,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wait,
    output logic              pclk,
    output logic [EXT_AW-1:0] ext_addr,
    output logic              ext_sel,
    output logic              busy,
    output logic              done
);
    logic              cyc_ext_q;
    logic              rd_ext_q;
    logic              is_ext;
    logic [EXT_AW-1:0] dec_addr;
    logic [CNT_W-1:0]  hi_len;
    logic [CNT_W-1:0]  lo_len;
    logic              accept;
    logic              sel_q;
    logic [EXT_AW-1:0] addr_q;

    // Extend bits, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_ext_q <= 1'b0;
            rd_ext_q  <= 1'b0;
        end else if (cfg_we) begin
            cyc_ext_q <= cfg_cyc_ext;
            rd_ext_q  <= cfg_rd_ext;
        end
    end

    pbt_addr_dec #(.ADDR_W(ADDR_W), .EXT_AW(EXT_AW)) dec_i (
        .kind     (req_kind),
        .addr     (req_addr),
        .is_ext   (is_ext),
        .ext_addr (dec_addr)
    );

    pbt_shape #(.CNT_W(CNT_W)) shape_i (
        .kind    (req_kind),
        .is_ext  (is_ext),
        .wait_st (req_wait),
        .cyc_ext (cyc_ext_q),
        .rd_ext  (rd_ext_q),
        .hi_len  (hi_len),
        .lo_len  (lo_len)
    );

    pbt_phase_gen #(.CNT_W(CNT_W)) phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (req_valid),
        .hi_len    (hi_len),
        .lo_len    (lo_len),
        .accept    (accept),
        .pclk      (pclk),
        .busy      (busy),
        .done      (done)
    );

    // External select and address for the running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end else if (accept) begin
            sel_q  <= is_ext;
            addr_q <= dec_addr;
        end else if (done) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end
    end

    assign ext_sel  = sel_q;
    assign ext_addr = addr_q;
endmodule

// File: rtl/pbus_cycle_ctrl_chk.sv
// Checker for pbus_cycle_ctrl, bound to every instance of it.
module pbus_cycle_ctrl_chk #(
    parameter int EXT_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              pclk,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              ext_sel,
    input logic              busy,
    input logic              done
);
    AST_DONE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !pclk)); // R2
    AST_EXT_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_sel |-> (ext_addr == '0)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pclk && !ext_sel && !done)); // R11
    AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(ext_sel) && $stable(ext_addr))); // R7
    AST_HIGH_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk && $past(pclk)) |=> !pclk); // R4
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> (pclk && busy)); // R10
endmodule

bind pbus_cycle_ctrl pbus_cycle_ctrl_chk #(.EXT_AW(EXT_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pclk      (pclk),
    .ext_addr  (ext_addr),
    .ext_sel   (ext_sel),
    .busy      (busy),
    .done      (done)
);

// File: tb/pbus_cycle_ctrl_tb_top.sv
module pbus_cycle_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_cyc_ext = 1'b0;
    logic       cfg_rd_ext = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [4:0] req_addr = 5'd0;
    logic       req_wait = 1'b0;
    logic       pclk;
    logic [2:0] ext_addr;
    logic       ext_sel;
    logic       busy;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;
    int ticks   = 0;

    always #5 clk = ~clk;
    always @(posedge clk) ticks <= ticks + 1;

    pbus_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cyc_ext(cfg_cyc_ext),
        .cfg_rd_ext(cfg_rd_ext), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wait(req_wait), .pclk(pclk),
        .ext_addr(ext_addr), .ext_sel(ext_sel), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [1:0] kind;
        logic [4:0] addr;
        logic       wt;
        logic       c7;
        logic       c13;
        logic [2:0] hi;
        logic [2:0] lo;
        logic       sel;
        logic [2:0] ea;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 5'h05, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 1'b0, 3'd0}, // R2
        '{2'd1, 5'h1A, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 1'b0, 3'd0}, // R8 user ignores window
        '{2'd2, 5'h1B, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 1'b1, 3'd3}, // R7
        '{2'd3, 5'h1F, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 1'b1, 3'd7}, // R7
        '{2'd2, 5'h17, 1'b0, 1'b0, 1'b1, 3'd1, 3'd1, 1'b0, 3'd0}, // R6 R8 internal read
        '{2'd0, 5'h02, 1'b1, 1'b0, 1'b0, 3'd1, 3'd3, 1'b0, 3'd0}, // R3
        '{2'd1, 5'h00, 1'b0, 1'b1, 1'b0, 3'd2, 3'd2, 1'b0, 3'd0}, // R4
        '{2'd2, 5'h18, 1'b0, 1'b0, 1'b1, 3'd2, 3'd2, 1'b1, 3'd0}, // R5
        '{2'd3, 5'h1C, 1'b0, 1'b0, 1'b1, 3'd1, 3'd1, 1'b1, 3'd4}, // R5 write
        '{2'd1, 5'h03, 1'b0, 1'b0, 1'b1, 3'd1, 3'd1, 1'b0, 3'd0}, // R6
        '{2'd2, 5'h19, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1, 1'b1, 3'd1}, // R6
        '{2'd1, 5'h07, 1'b1, 1'b1, 1'b0, 3'd2, 3'd4, 1'b0, 3'd0}, // R9
        '{2'd2, 5'h1E, 1'b1, 1'b0, 1'b1, 3'd2, 3'd4, 1'b1, 3'd6}, // R9
        '{2'd3, 5'h1D, 1'b1, 1'b0, 1'b0, 3'd1, 3'd3, 1'b1, 3'd5}  // R3
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic c7, input logic c13);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cyc_ext = c7; cfg_rd_ext = c13;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request from idle and measure the strobe shape.
    task automatic run_one(input logic [1:0] k, input logic [4:0] a, input logic w,
                           output int hi, output int lo, output int sel,
                           output int ea, output int busy_ok);
        hi = 0; lo = 0; sel = -1; ea = -1; busy_ok = 1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wait = w;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!busy) busy_ok = 0;
            if (sel < 0) begin sel = int'(ext_sel); ea = int'(ext_addr); end
            if (pclk) hi++;
            else lo++;
            if (done) break;
        end
    endtask

    initial begin
        int hi, lo, sel, ea, bok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pclk", int'(pclk), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 ext_sel", int'(ext_sel), 0);
        check("R1 ext_addr", int'(ext_addr), 0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("row%0d", i);
            set_cfg(TBL[i].c7, TBL[i].c13);
            run_one(TBL[i].kind, TBL[i].addr, TBL[i].wt, hi, lo, sel, ea, bok);
            check({tg, " high ticks"}, hi, int'(TBL[i].hi));
            check({tg, " low ticks"}, lo, int'(TBL[i].lo));
            check({tg, " ext_sel"}, sel, int'(TBL[i].sel));
            check({tg, " ext_addr"}, ea, int'(TBL[i].ea));
            check({tg, " R11 busy during cycle"}, bok, 1);
            @(negedge clk);
            check({tg, " R11 idle after done"}, int'(busy), 0);
            check({tg, " R11 pclk idle"}, int'(pclk), 0);
        end

        // R10 back-to-back: first access plain, second queued at done tick
        set_cfg(1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_addr = 5'd0; req_wait = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd3; req_addr = 5'h1A; req_wait = 1'b0;
        check("R10 first high", int'(pclk), 1);
        @(negedge clk);
        check("R10 done tick", int'(done), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 next high without gap", int'(pclk), 1);
        check("R10 busy kept", int'(busy), 1);
        check("R7 second ext_addr", int'(ext_addr), 2);
        repeat (3) @(negedge clk);

        // R1 reset clears the extend bits
        set_cfg(1'b1, 1'b1);
        run_one(2'd1, 5'd0, 1'b0, hi, lo, sel, ea, bok);
        check("R4 stretched before reset", hi, 2);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_one(2'd1, 5'd0, 1'b0, hi, lo, sel, ea, bok);
        check("R1 user high after reset", hi, 1);
        check("R1 user low after reset", lo, 1);
        run_one(2'd2, 5'h1B, 1'b0, hi, lo, sel, ea, bok);
        check("R1 read high after reset", hi, 1);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    always @(negedge clk) begin
        if (ticks > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", ticks, 20000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule